// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Interface

This block is the slave side of a host processor port that gives access to a small bank of 8-bit registers. Address, write data and read data travel on separate buses. A static mode input selects one of two handshakes. In the clocked handshake, an address strobe that lasts one cycle starts an access, and a transfer acknowledge that lasts one cycle ends it. In the strobe handshake, the strobes are held low for the whole access. They are brought into the block's clock domain through two-flop synchronizers. The acknowledge then stays active until the host withdraws any one of the qualifying strobes.

The acknowledge and the read data each come with an output enable, which the pad ring uses to drive or release the shared lines. In clocked mode the host clock must be the clock `clk` that the block runs on. In strobe mode, `clk` is a free-running internal clock and the host strobes have no timing relation to it. A synchronous active-high reset clears every register and returns the handshake to idle.

Top module: `hostbus_slave`

## Requirements
- R1: While and after `rst` is high, `ack_n` is 1, `ack_oe` is 0 and `rdata_oe` is 0, and every register in the file reads back as 0x00.
- R2: While `cs_n` is 1, no access takes place in either mode: `ack_n` stays 1 and no register changes, whatever the other strobes do.
- R3: In clocked mode (`mode_sync`=1), when `cs_n` and `as_n` are both sampled low at a rising edge, `ack_n` is 0 for exactly the following cycle.
- R4: In clocked mode, a write (`rd_wr`=0) stores `wdata` at `addr`. A later read returns that value.
- R5: In clocked mode, during a read (`rd_wr`=1), `rdata` holds the addressed value and `rdata_oe` is 1 in the same cycle that `ack_n` is 0. In other cycles `rdata_oe` is 0.
- R6: In clocked mode the level on `ds_n` has no effect on any access.
- R7: In strobe mode (`mode_sync`=0), an access needs `cs_n`, `as_n` and `ds_n` all low. `ack_n` falls at the third rising edge after they go low, and it stays high before that edge.
- R8: In strobe mode, `ack_n` stays 0 for as long as all three strobes stay low. It returns to 1 at the third rising edge after any one of `ds_n`, `as_n` or `cs_n` goes high.
- R9: `rdata_oe` is 1 only while `ack_n` is 0 on a read access. In strobe mode it rises and falls together with the acknowledge, and during that window `rdata` holds the addressed value.
- R10: Reads from an address at or above the register count return 0x00. Writes to such an address change nothing. Both kinds of access are still acknowledged.
- R11: `ack_oe` is 1 whenever `ack_n` is 0. It falls one edge after `cs_n` rises in clocked mode, and three edges after `cs_n` rises in strobe mode.
- R12: In strobe mode, a write stores `wdata` at `addr` and a read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the host clock in clocked mode |
| rst | input | 1 | Synchronous active-high reset |
| mode_sync | input | 1 | Static handshake select: 1 clocked, 0 strobe |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low (strobe mode only) |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| addr | input | AW (8) | Register address |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data toward the bus pads |
| rdata_oe | output | 1 | Read data bus drive enable |
| ack_n | output | 1 | Transfer acknowledge, active low |
| ack_oe | output | 1 | Acknowledge drive enable |

## Verification
The bench walks through every register address, plus a few addresses past the end of the file, in both handshake modes. Each address gets a data value derived from the address, and each mode uses a different formula, so a value left over from the other mode, a wrong address decode, or a leaked out-of-range write shows up in the readback. Clocked accesses alternate the level of `ds_n`, which shows whether that line is really ignored. Strobe accesses rotate which strobe is withdrawn first, so each of the three release paths is exercised, and the acknowledge is sampled edge by edge to show its exact latency. Deselected strobes, and a strobe-mode access without a data strobe, are checked against both the acknowledge pins and the register contents.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  // handshake controller states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,  // clocked mode: acknowledge held for a single cycle
    ST_HOLD  = 2'd2   // strobe mode: acknowledge held until a strobe drops
  } hbus_state_t;

  localparam logic RW_READ   = 1'b1;
  localparam logic MODE_SYNC = 1'b1;
endpackage

// File: rtl/hbus_sync2.sv
module hbus_sync2 #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i] <= RST_VAL[i];
        stage2[i] <= RST_VAL[i];
      end else begin
        stage1[i] <= d[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign q = stage2;
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW:0] LIMIT = (AW+1)'(NREG);

  logic [DW-1:0] mem_q [NREG];
  logic          in_range;
  logic [IW-1:0] idx;

  assign in_range = ({1'b0, addr} < LIMIT);
  assign idx      = addr[IW-1:0];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        mem_q[r] <= '0;
      else if (we && in_range && (idx == IW'(r)))
        mem_q[r] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_range)
      rdata = mem_q[idx];
  end
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_sync,
  input  logic cs_n,
  input  logic as_n,
  input  logic ds_n,
  input  logic rd_wr,
  output logic do_access,
  output logic ack_n,
  output logic ack_oe,
  output logic rdata_oe
);
  hbus_state_t state_q, state_d;
  logic [2:0]  strb_syn_n;
  logic        q_async;
  logic        start_s, start_a, start;
  logic        oe_q, oe_d;
  logic        ackoe_q;

  // strobe-mode strobes cross into clk through two flops
  hbus_sync2 #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, as_n, ds_n}),
    .q   (strb_syn_n)
  );

  assign q_async = ~|strb_syn_n;
  assign start_s = ~cs_n & ~as_n;
  assign start_a = (state_q == ST_IDLE) & q_async;
  assign start   = (mode_sync == MODE_SYNC) ? start_s : start_a;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = (mode_sync == MODE_SYNC) ? ST_PULSE : ST_HOLD;
      ST_PULSE: state_d = (start && mode_sync == MODE_SYNC) ? ST_PULSE : ST_IDLE;
      ST_HOLD:  if (!q_async || mode_sync == MODE_SYNC) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    oe_d = oe_q;
    if (start)
      oe_d = (rd_wr == RW_READ);
    else if (state_d == ST_IDLE)
      oe_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      ackoe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      oe_q    <= oe_d;
      ackoe_q <= (mode_sync == MODE_SYNC) ? ~cs_n : ~strb_syn_n[2];
    end
  end

  assign do_access = start;
  assign ack_n     = (state_q == ST_IDLE);
  assign ack_oe    = ackoe_q;
  assign rdata_oe  = oe_q;
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hbus_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_sync,
  input  logic          cs_n,
  input  logic          as_n,
  input  logic          ds_n,
  input  logic          rd_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          ack_n,
  output logic          ack_oe
);
  logic          do_access;
  logic [DW-1:0] rf_rdata;
  logic [DW-1:0] rdata_q;
  logic          is_read;

  assign is_read = (rd_wr == RW_READ);

  hbus_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_sync (mode_sync),
    .cs_n      (cs_n),
    .as_n      (as_n),
    .ds_n      (ds_n),
    .rd_wr     (rd_wr),
    .do_access (do_access),
    .ack_n     (ack_n),
    .ack_oe    (ack_oe),
    .rdata_oe  (rdata_oe)
  );

  hbus_regfile #(.AW(AW), .DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (do_access & ~is_read),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (do_access && is_read)
      rdata_q <= rf_rdata;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/hbus_chk.sv
module hbus_chk (
  input logic clk,
  input logic rst,
  input logic mode_sync,
  input logic cs_n,
  input logic as_n,
  input logic ds_n,
  input logic ack_n,
  input logic ack_oe,
  input logic rdata_oe
);
  p_ackoe_cover_r11: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> ack_oe);

  p_oe_needs_ack_r9: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> !ack_n);

  p_sync_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_sync && $past(mode_sync) && !ack_n) |-> $past(!cs_n && !as_n));

  p_sync_deselect_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_sync && $past(mode_sync) && $past(cs_n)) |-> ack_n);

  p_async_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (!mode_sync && $past(!mode_sync) && $fell(ack_n)) |-> $past(!ds_n && !as_n && !cs_n, 3));

  p_async_release_r8: assert property (@(posedge clk) disable iff (rst)
    (!mode_sync && $past(!mode_sync) && $rose(ack_n)) |-> $past(ds_n || as_n || cs_n, 3));
endmodule

bind hostbus_slave hbus_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_sync (mode_sync),
  .cs_n      (cs_n),
  .as_n      (as_n),
  .ds_n      (ds_n),
  .ack_n     (ack_n),
  .ack_oe    (ack_oe),
  .rdata_oe  (rdata_oe)
);

// File: tb/sim_hostbus_slave.sv
`timescale 1ns/1ps
module sim_hostbus_slave;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int NREG = 16;
  localparam int NA   = NREG + 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          mode_sync;
  logic          cs_n, as_n, ds_n, rd_wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_oe, ack_n, ack_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hostbus_slave #(.AW(AW), .DW(DW), .NREG(NREG)) u0 (
    .clk(clk), .rst(rst), .mode_sync(mode_sync), .cs_n(cs_n), .as_n(as_n),
    .ds_n(ds_n), .rd_wr(rd_wr), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .ack_n(ack_n), .ack_oe(ack_oe)
  );

  function automatic int pat_s(int a);
    return (a * 37 + 5) & 255;
  endfunction

  function automatic int pat_a(int a);
    return ((a * 91 + 200) & 255) ^ 8'h5A;
  endfunction

  function automatic int expect_rd(int a, int v);
    return (a < NREG) ? v : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; as_n = 1'b1; ds_n = 1'b1;
  endtask

  task automatic sync_acc(input bit rd, input int a, input int d, input bit dsv, output int rv);
    @(negedge clk);
    cs_n = 1'b0; as_n = 1'b0; ds_n = dsv; rd_wr = rd;
    addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    chk("R3 ack low after strobe edge", int'(ack_n), 0);
    chk("R11 ack_oe during ack", int'(ack_oe), 1);
    chk("R5 rdata_oe matches read", int'(rdata_oe), int'(rd));
    rv = int'(rdata);
    idle_bus();
    @(negedge clk);
    chk("R3 ack single cycle", int'(ack_n), 1);
    chk("R5 rdata_oe released", int'(rdata_oe), 0);
  endtask

  task automatic async_acc(input bit rd, input int a, input int d, input int rel, output int rv);
    @(negedge clk);
    cs_n = 1'b0; as_n = 1'b0; ds_n = 1'b0; rd_wr = rd;
    addr = AW'(a); wdata = DW'(d);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R7 ack not before third edge", int'(ack_n), 1);
    end
    @(negedge clk);
    chk("R7 ack at third edge", int'(ack_n), 0);
    chk("R9 rdata_oe with ack", int'(rdata_oe), int'(rd));
    chk("R11 ack_oe during ack", int'(ack_oe), 1);
    rv = int'(rdata);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 ack held", int'(ack_n), 0);
    end
    case (rel)
      0: ds_n = 1'b1;
      1: as_n = 1'b1;
      default: cs_n = 1'b1;
    endcase
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R8 ack held through sync", int'(ack_n), 0);
    end
    @(negedge clk);
    chk("R8 ack released", int'(ack_n), 1);
    chk("R9 rdata_oe released", int'(rdata_oe), 0);
    idle_bus();
    repeat (3) @(negedge clk);
    chk("R11 ack_oe off after deselect", int'(ack_oe), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rv;
    rst = 1'b1; mode_sync = 1'b1; rd_wr = 1'b1; addr = '0; wdata = '0;
    idle_bus();
    repeat (4) @(negedge clk);
    chk("R1 ack_n in reset", int'(ack_n), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack_n after reset", int'(ack_n), 1);
    chk("R1 ack_oe after reset", int'(ack_oe), 0);
    chk("R1 rdata_oe after reset", int'(rdata_oe), 0);

    // clocked mode: reset contents
    for (int a = 0; a < NA; a++) begin
      sync_acc(1'b1, a, 0, 1'b1, rv);
      chk("R1 register cleared", rv, 0);
    end
    // clocked writes with ds_n alternating (R6)
    for (int a = 0; a < NA; a++)
      sync_acc(1'b0, a, pat_s(a), a[0], rv);
    for (int a = 0; a < NA; a++) begin
      sync_acc(1'b1, a, 0, ~a[0], rv);
      chk("R4 R10 R6 clocked readback", rv, expect_rd(a, pat_s(a)));
    end

    // clocked deselected strobe (R2)
    @(negedge clk);
    cs_n = 1'b1; as_n = 1'b0; ds_n = 1'b0; rd_wr = 1'b0; addr = 8'd3; wdata = 8'hAA;
    @(negedge clk);
    chk("R2 no ack when deselected", int'(ack_n), 1);
    chk("R11 ack_oe off when deselected", int'(ack_oe), 0);
    idle_bus();
    sync_acc(1'b1, 3, 0, 1'b1, rv);
    chk("R2 register unchanged", rv, pat_s(3));

    // strobe mode
    @(negedge clk);
    mode_sync = 1'b0;
    repeat (4) @(negedge clk);
    for (int a = 0; a < NA; a++)
      async_acc(1'b0, a, pat_a(a), a % 3, rv);
    for (int a = 0; a < NA; a++) begin
      async_acc(1'b1, a, 0, (a + 1) % 3, rv);
      chk("R12 R10 strobe readback", rv, expect_rd(a, pat_a(a)));
    end

    // strobe mode deselected (R2)
    @(negedge clk);
    cs_n = 1'b1; as_n = 1'b0; ds_n = 1'b0; rd_wr = 1'b0; addr = 8'd5; wdata = 8'h11;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2 strobe mode no ack deselected", int'(ack_n), 1);
    end
    chk("R11 ack_oe off deselected", int'(ack_oe), 0);
    idle_bus();
    repeat (4) @(negedge clk);

    // strobe mode without data strobe (R7)
    cs_n = 1'b0; as_n = 1'b0; ds_n = 1'b1; rd_wr = 1'b0; addr = 8'd6; wdata = 8'h22;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7 no ack without ds_n", int'(ack_n), 1);
    end
    idle_bus();
    repeat (4) @(negedge clk);
    async_acc(1'b1, 5, 0, 2, rv);
    chk("R2 strobe register 5 unchanged", rv, pat_a(5));
    async_acc(1'b1, 6, 0, 0, rv);
    chk("R7 register 6 unchanged", rv, pat_a(6));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule